// File: doc/BRIEF.md
# Shadow-to-Unified TLB Miss Arbiter

This block is the control path between two small shadow translation buffers, one serving instruction fetch and one serving data access, and the larger unified translation buffer they share. A lookup that hits in its own shadow buffer passes through with no stall and never touches the unified buffer. A shadow miss stalls its requester and opens an access to the unified buffer. The access lasts a fixed number of cycles, which differs per side. When it completes, the unified lookup result decides the outcome. A hit raises a one-cycle refill strobe that copies the entry into the requesting shadow buffer. A miss raises a one-cycle exception pulse for that side.

Only one unified access is open at a time. The state machine has three states: `ST_IDLE`, `ST_DATA` (data access open) and `ST_INST` (instruction access open). It has these transitions:
- `ST_IDLE`→`ST_DATA` on a data miss.
- `ST_IDLE`→`ST_INST` on an instruction miss with no data miss.
- `ST_DATA`→`ST_INST` when the data access completes and an instruction miss is waiting.
- `ST_DATA`→`ST_IDLE` when the data access completes and nothing is waiting.
- `ST_INST`→`ST_DATA` when the instruction access completes and a data miss is waiting.
- `ST_INST`→`ST_IDLE` when the instruction access completes and nothing is waiting.

The data side wins when both sides miss in the same idle cycle. A requester keeps its request and shadow-hit inputs steady while stalled. After an exception it withdraws or changes its request.

Top module: `tlb_miss_arbiter`

## Requirements
- R1: A request presented with its shadow-hit input high raises no stall and opens no unified access for that side.
- R2: A data miss (`dat_req`=1, `dat_shadow_hit`=0) seen in `ST_IDLE` raises `uni_grant_dat` from the next cycle for exactly DAT_LAT (default 3) consecutive cycles.
- R3: An instruction miss seen in `ST_IDLE` with no data miss raises `uni_grant_ins` from the next cycle for exactly INS_LAT (default 4) consecutive cycles.
- R4: When both sides miss in the same `ST_IDLE` cycle, the data side is granted first.
- R5: A miss arriving while the other side holds the unified buffer waits. It is granted in the cycle right after that access's last cycle, and receives its own full latency from then.
- R6: In the last grant cycle of an access, `uni_hit`=1 produces a one-cycle refill strobe for the served side and no exception.
- R7: In the last grant cycle of an access, `uni_hit`=0 produces a one-cycle miss-exception pulse for the served side and no refill.
- R8: A side's stall is high exactly when that side presents a miss or holds the grant.
- R9: The two grants are never high together.
- R10: While the synchronous reset `rst` is high, every output is 0. The machine is in `ST_IDLE` after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_req | input | 1 | Instruction-side translation request |
| ins_shadow_hit | input | 1 | Instruction shadow buffer hit for the current request |
| dat_req | input | 1 | Data-side translation request |
| dat_shadow_hit | input | 1 | Data shadow buffer hit for the current request |
| uni_hit | input | 1 | Unified buffer lookup result, sampled in an access's last cycle |
| ins_stall | output | 1 | Stall to the instruction requester |
| dat_stall | output | 1 | Stall to the data requester |
| uni_grant_ins | output | 1 | Unified buffer held by the instruction side |
| uni_grant_dat | output | 1 | Unified buffer held by the data side |
| ins_refill | output | 1 | Write strobe into the instruction shadow buffer |
| dat_refill | output | 1 | Write strobe into the data shadow buffer |
| ins_miss_exc | output | 1 | Instruction-side translation-miss exception pulse |
| dat_miss_exc | output | 1 | Data-side translation-miss exception pulse |

## Verification
Several properties are checked on every cycle: the grants never overlap, refill and exception never coincide and only occur while granted, a completion falls exactly on the side's latency, data wins a simultaneous idle miss, a shadow hit never stalls, and outputs stay quiet in reset. Some behaviour can only be shown through the bench's scenarios, because it spans a whole exchange. This covers the hand-over of a waiting instruction miss right after a data access, the full grant length the waiting side then receives, and the link between stall release, refill and the requester's next shadow hit. Random traffic drives these against a reference model.

// File: rtl/tlbarb_pkg.sv
package tlbarb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_INST = 2'd2
    } arb_state_e;

    localparam int SIDE_DAT = 0;
    localparam int SIDE_INS = 1;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/tlbarb_lat_cnt.sv
module tlbarb_lat_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Remaining cycles reach zero in the last cycle of an access
    assign done = (cnt_q == '0);
endmodule

// File: rtl/tlbarb_fsm.sv
module tlbarb_fsm
    import tlbarb_pkg::*;
#(
    parameter int INS_LAT = 4,
    parameter int DAT_LAT = 3,
    parameter int CNT_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SIDES-1:0] miss,
    input  logic                 done,
    output logic [NUM_SIDES-1:0] grant,
    output logic                 load,
    output logic [CNT_W-1:0]     load_val
);
    localparam logic [CNT_W-1:0] INS_LOAD = CNT_W'(INS_LAT - 1);
    localparam logic [CNT_W-1:0] DAT_LOAD = CNT_W'(DAT_LAT - 1);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss[SIDE_DAT]) begin
                    state_d  = ST_DATA;
                    load     = 1'b1;
                    load_val = DAT_LOAD;
                end else if (miss[SIDE_INS]) begin
                    state_d  = ST_INST;
                    load     = 1'b1;
                    load_val = INS_LOAD;
                end
            end
            ST_DATA: begin
                if (done) begin
                    if (miss[SIDE_INS]) begin
                        state_d  = ST_INST;
                        load     = 1'b1;
                        load_val = INS_LOAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_INST: begin
                if (done) begin
                    if (miss[SIDE_DAT]) begin
                        state_d  = ST_DATA;
                        load     = 1'b1;
                        load_val = DAT_LOAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        grant           = '0;
        grant[SIDE_DAT] = !rst && (state_q == ST_DATA);
        grant[SIDE_INS] = !rst && (state_q == ST_INST);
    end
endmodule

// File: rtl/tlbarb_side.sv
module tlbarb_side (
    input  logic rst,
    input  logic req,
    input  logic shadow_hit,
    input  logic granted,
    input  logic done,
    input  logic uni_hit,
    output logic miss,
    output logic stall,
    output logic refill,
    output logic miss_exc
);
    logic finishing;

    always_comb begin
        miss      = req && !shadow_hit;
        finishing = !rst && granted && done;
        stall     = !rst && (miss || granted);
        refill    = finishing && uni_hit;
        miss_exc  = finishing && !uni_hit;
    end
endmodule

// File: rtl/tlb_miss_arbiter.sv
module tlb_miss_arbiter
    import tlbarb_pkg::*;
#(
    parameter int INS_LAT = 4,
    parameter int DAT_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ins_req,
    input  logic ins_shadow_hit,
    input  logic dat_req,
    input  logic dat_shadow_hit,
    input  logic uni_hit,
    output logic ins_stall,
    output logic dat_stall,
    output logic uni_grant_ins,
    output logic uni_grant_dat,
    output logic ins_refill,
    output logic dat_refill,
    output logic ins_miss_exc,
    output logic dat_miss_exc
);
    localparam int MAX_LAT = (INS_LAT > DAT_LAT) ? INS_LAT : DAT_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    logic [NUM_SIDES-1:0] req_v, hit_v, miss_v, grant_v;
    logic [NUM_SIDES-1:0] stall_v, refill_v, exc_v;
    logic                 done, load;
    logic [CNT_W-1:0]     load_val;

    assign req_v = {ins_req, dat_req};
    assign hit_v = {ins_shadow_hit, dat_shadow_hit};

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            tlbarb_side u_side (
                .rst        (rst),
                .req        (req_v[s]),
                .shadow_hit (hit_v[s]),
                .granted    (grant_v[s]),
                .done       (done),
                .uni_hit    (uni_hit),
                .miss       (miss_v[s]),
                .stall      (stall_v[s]),
                .refill     (refill_v[s]),
                .miss_exc   (exc_v[s])
            );
        end
    endgenerate

    tlbarb_fsm #(
        .INS_LAT (INS_LAT),
        .DAT_LAT (DAT_LAT),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .miss     (miss_v),
        .done     (done),
        .grant    (grant_v),
        .load     (load),
        .load_val (load_val)
    );

    tlbarb_lat_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    assign ins_stall     = stall_v[SIDE_INS];
    assign dat_stall     = stall_v[SIDE_DAT];
    assign uni_grant_ins = grant_v[SIDE_INS];
    assign uni_grant_dat = grant_v[SIDE_DAT];
    assign ins_refill    = refill_v[SIDE_INS];
    assign dat_refill    = refill_v[SIDE_DAT];
    assign ins_miss_exc  = exc_v[SIDE_INS];
    assign dat_miss_exc  = exc_v[SIDE_DAT];
endmodule

// File: rtl/tlb_miss_arbiter_chk.sv
module tlb_miss_arbiter_chk #(
    parameter int INS_LAT = 4,
    parameter int DAT_LAT = 3
) (
    input logic clk,
    input logic rst,
    input logic ins_req,
    input logic ins_shadow_hit,
    input logic dat_req,
    input logic dat_shadow_hit,
    input logic uni_hit,
    input logic ins_stall,
    input logic dat_stall,
    input logic uni_grant_ins,
    input logic uni_grant_dat,
    input logic ins_refill,
    input logic dat_refill,
    input logic ins_miss_exc,
    input logic dat_miss_exc
);
    localparam int RW = 16;

    logic [RW-1:0] run_dat, run_ins;
    logic          any_grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_dat     <= '0;
            run_ins     <= '0;
            any_grant_q <= 1'b0;
        end else begin
            run_dat     <= uni_grant_dat ? run_dat + 1'b1 : '0;
            run_ins     <= uni_grant_ins ? run_ins + 1'b1 : '0;
            any_grant_q <= uni_grant_dat || uni_grant_ins;
        end
    end

    // R9
    p_single_owner_r9: assert property (@(posedge clk) disable iff (rst)
        !(uni_grant_dat && uni_grant_ins));

    // R6 / R7
    p_dat_outcome_r6: assert property (@(posedge clk) disable iff (rst)
        !(dat_refill && dat_miss_exc));
    p_ins_outcome_r7: assert property (@(posedge clk) disable iff (rst)
        !(ins_refill && ins_miss_exc));
    p_dat_done_at_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (dat_refill || dat_miss_exc) |-> (uni_grant_dat && run_dat == RW'(DAT_LAT - 1)));
    p_ins_done_at_lat_r3: assert property (@(posedge clk) disable iff (rst)
        (ins_refill || ins_miss_exc) |-> (uni_grant_ins && run_ins == RW'(INS_LAT - 1)));
    p_dat_no_overrun_r2: assert property (@(posedge clk) disable iff (rst)
        uni_grant_dat |-> (run_dat < RW'(DAT_LAT)));
    p_ins_no_overrun_r3: assert property (@(posedge clk) disable iff (rst)
        uni_grant_ins |-> (run_ins < RW'(INS_LAT)));

    // R4
    p_data_first_r4: assert property (@(posedge clk) disable iff (rst)
        (!uni_grant_dat && !uni_grant_ins && dat_req && !dat_shadow_hit
         && ins_req && !ins_shadow_hit) |=> uni_grant_dat);

    // R1
    p_hit_no_stall_r1: assert property (@(posedge clk) disable iff (rst)
        (dat_req && dat_shadow_hit && !uni_grant_dat) |-> !dat_stall);

    // R8
    p_grant_stalls_r8: assert property (@(posedge clk) disable iff (rst)
        (uni_grant_ins |-> ins_stall) and (uni_grant_dat |-> dat_stall));

    // R10
    always @(posedge clk) begin
        if (rst) begin
            p_quiet_in_reset_r10: assert (!ins_stall && !dat_stall && !uni_grant_ins
                && !uni_grant_dat && !ins_refill && !dat_refill
                && !ins_miss_exc && !dat_miss_exc);
        end
    end
endmodule

bind tlb_miss_arbiter tlb_miss_arbiter_chk #(
    .INS_LAT (INS_LAT),
    .DAT_LAT (DAT_LAT)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ins_req        (ins_req),
    .ins_shadow_hit (ins_shadow_hit),
    .dat_req        (dat_req),
    .dat_shadow_hit (dat_shadow_hit),
    .uni_hit        (uni_hit),
    .ins_stall      (ins_stall),
    .dat_stall      (dat_stall),
    .uni_grant_ins  (uni_grant_ins),
    .uni_grant_dat  (uni_grant_dat),
    .ins_refill     (ins_refill),
    .dat_refill     (dat_refill),
    .ins_miss_exc   (ins_miss_exc),
    .dat_miss_exc   (dat_miss_exc)
);

// File: tb/tlb_miss_arbiter_test.sv
`timescale 1ns/1ps
module tlb_miss_arbiter_test;
    localparam int INS_LAT = 4;
    localparam int DAT_LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_req = 1'b0, ins_shadow_hit = 1'b0;
    logic dat_req = 1'b0, dat_shadow_hit = 1'b0;
    logic uni_hit = 1'b0;
    logic ins_stall, dat_stall, uni_grant_ins, uni_grant_dat;
    logic ins_refill, dat_refill, ins_miss_exc, dat_miss_exc;

    int n_chk = 0;
    int n_bad = 0;

    // reference model: 0 idle, 1 data access, 2 instruction access
    int m_state = 0;
    int m_run   = 0;
    logic e_dref, e_dexc, e_iref, e_iexc;

    always #10 clk = ~clk;

    tlb_miss_arbiter #(.INS_LAT(INS_LAT), .DAT_LAT(DAT_LAT)) uut (
        .clk(clk), .rst(rst),
        .ins_req(ins_req), .ins_shadow_hit(ins_shadow_hit),
        .dat_req(dat_req), .dat_shadow_hit(dat_shadow_hit),
        .uni_hit(uni_hit),
        .ins_stall(ins_stall), .dat_stall(dat_stall),
        .uni_grant_ins(uni_grant_ins), .uni_grant_dat(uni_grant_dat),
        .ins_refill(ins_refill), .dat_refill(dat_refill),
        .ins_miss_exc(ins_miss_exc), .dat_miss_exc(dat_miss_exc)
    );

    task automatic chk(input string tag, input string name, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
        end
    endtask

    function automatic logic is_done(input int st, input int run);
        return (st == 1 && run == DAT_LAT) || (st == 2 && run == INS_LAT);
    endfunction

    task automatic step(input logic r, input logic dr, input logic dh,
                        input logic ir, input logic ih, input logic uh);
        logic dmiss, imiss, gd, gi, dn;
        @(negedge clk);
        rst = r; dat_req = dr; dat_shadow_hit = dh;
        ins_req = ir; ins_shadow_hit = ih; uni_hit = uh;
        #1;
        dmiss = dr && !dh;
        imiss = ir && !ih;
        gd = !r && m_state == 1;
        gi = !r && m_state == 2;
        dn = !r && is_done(m_state, m_run);
        e_dref = gd && dn && uh;
        e_dexc = gd && dn && !uh;
        e_iref = gi && dn && uh;
        e_iexc = gi && dn && !uh;
        if (r) begin
            chk("R10", "dat_stall", dat_stall, 1'b0);
            chk("R10", "ins_stall", ins_stall, 1'b0);
            chk("R10", "grants", uni_grant_dat | uni_grant_ins, 1'b0);
            chk("R10", "strobes", dat_refill | ins_refill | dat_miss_exc | ins_miss_exc, 1'b0);
        end else begin
            chk("R2", "uni_grant_dat", uni_grant_dat, gd);
            chk("R3", "uni_grant_ins", uni_grant_ins, gi);
            chk("R9", "grant overlap", uni_grant_dat & uni_grant_ins, 1'b0);
            chk("R6", "dat_refill", dat_refill, e_dref);
            chk("R6", "ins_refill", ins_refill, e_iref);
            chk("R7", "dat_miss_exc", dat_miss_exc, e_dexc);
            chk("R7", "ins_miss_exc", ins_miss_exc, e_iexc);
            chk("R8", "dat_stall", dat_stall, dmiss || gd);
            chk("R8", "ins_stall", ins_stall, imiss || gi);
        end
        // advance the model to the next cycle
        if (r) begin
            m_state = 0; m_run = 0;
        end else if (m_state == 0) begin
            if (dmiss)      begin m_state = 1; m_run = 1; end
            else if (imiss) begin m_state = 2; m_run = 1; end
        end else if (!dn) begin
            m_run++;
        end else if (m_state == 1) begin
            if (imiss) begin m_state = 2; m_run = 1; end
            else       begin m_state = 0; m_run = 0; end
        end else begin
            if (dmiss) begin m_state = 1; m_run = 1; end
            else       begin m_state = 0; m_run = 0; end
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic aw_d, aw_i, ak_d, ak_i, dr, dh, ir, ih, rr;
        void'($urandom(32'd20240611));
        // R10: reset with busy inputs
        step(1, 1, 0, 1, 0, 0);
        step(1, 1, 0, 1, 0, 1);
        step(1, 0, 0, 0, 0, 0);

        // R1: shadow hits on both sides
        step(0, 1, 1, 1, 1, 0);
        chk("R1", "dat_stall on hit", dat_stall, 1'b0);
        chk("R1", "ins_stall on hit", ins_stall, 1'b0);
        step(0, 1, 1, 1, 1, 0);
        chk("R1", "grant after hit", uni_grant_dat | uni_grant_ins, 1'b0);

        // R4/R5/R6/R7: simultaneous misses
        step(0, 1, 0, 1, 0, 0);
        step(0, 1, 0, 1, 0, 0);
        chk("R4", "data granted first", uni_grant_dat, 1'b1);
        chk("R4", "inst held back", uni_grant_ins, 1'b0);
        step(0, 1, 0, 1, 0, 0);
        step(0, 1, 0, 1, 0, 1);
        chk("R6", "dat_refill on last cycle", dat_refill, 1'b1);
        step(0, 1, 1, 1, 0, 0);
        chk("R5", "inst granted right after data", uni_grant_ins, 1'b1);
        chk("R1", "data stall released on refilled hit", dat_stall, 1'b0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R5", "inst still granted, full latency", ins_miss_exc, 1'b0);
        step(0, 0, 0, 1, 0, 0);
        chk("R7", "ins_miss_exc on unified miss", ins_miss_exc, 1'b1);
        chk("R7", "no ins refill", ins_refill, 1'b0);
        step(0, 0, 0, 0, 0, 0);
        chk("R3", "grant dropped after access", uni_grant_ins, 1'b0);

        // random traffic from two requesters
        aw_d = 0; aw_i = 0; ak_d = 0; ak_i = 0;
        for (int c = 0; c < 4000; c++) begin
            rr = ($urandom % 200) == 0;
            if (ak_d)      begin dr = 1; dh = 1; ak_d = 0; end
            else if (aw_d) begin dr = 1; dh = 0; end
            else begin
                dr = ($urandom % 3) != 0; dh = $urandom % 2;
                aw_d = dr && !dh;
            end
            if (ak_i)      begin ir = 1; ih = 1; ak_i = 0; end
            else if (aw_i) begin ir = 1; ih = 0; end
            else begin
                ir = ($urandom % 3) != 0; ih = $urandom % 2;
                aw_i = ir && !ih;
            end
            step(rr, dr, dh, ir, ih, logic'($urandom % 4 != 0));
            if (rr) begin aw_d = 0; aw_i = 0; ak_d = 0; ak_i = 0; end
            if (e_dref) begin aw_d = 0; ak_d = 1; end
            if (e_dexc) aw_d = 0;
            if (e_iref) begin aw_i = 0; ak_i = 1; end
            if (e_iexc) aw_i = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule